// File: doc/BRIEF.md
# Vectored Interrupt Entry Port

This block sits on the processor side of an external vectored interrupt controller. Two active-low request lines arrive from the controller: one for fast interrupts and one for normal interrupts. Each line passes through a two-stage synchronizer, or straight through when its bypass control is set. The block drives a pending flag for each interrupt class.

When the processor starts normal-interrupt entry, it pulses `irqTake`. With vectoring enabled, the port raises an acknowledge and waits for the controller's valid strobe. On the first synchronized cycle in which that strobe is high, the port captures the 30-bit handler address and appends two zero bits to form the jump target. It drops the acknowledge, pulses `vecReady` and waits for the strobe to fall. With vectoring disabled, the port loads a fixed legacy vector instead and never raises the acknowledge. Fast interrupts never fetch a vector. The valid strobe has its own synchronizer with its own bypass, separate from the request bypass.

Top module: `irq_vector_port`

## Requirements
- R1: While `rstN` is low, `irqAck`, `vecReady`, `fiqPending` and `irqPending` are 0 and `jumpTarget` is 0.
- R2: A request input that is driven 0 makes its pending flag read 1; a request input at 1 makes the flag read 0.
- R3: With `reqSyncBypass`=0, a change on a request input reaches its pending flag after two rising clock edges. With `reqSyncBypass`=1, the change reaches the flag in the same cycle, with no edge in between.
- R4: With `validSyncBypass`=0, the port sees `irqAddrValid` two rising edges late. With `validSyncBypass`=1, it sees the strobe directly. This setting does not depend on `reqSyncBypass`.
- R5: In the idle state, with `vectorEnable`=1 and the synchronized valid low, a 1 on `irqTake` sets `irqAck` to 1 after the next rising edge.
- R6: `irqAck` stays 1 until the synchronized valid is seen high. At that edge the port stores `jumpTarget = {irqAddr, 2'b00}`, clears `irqAck` and sets `vecReady` for exactly one cycle.
- R7: The acknowledge is never raised while the synchronized valid is high. If `irqTake` arrives in that condition, `irqAck` rises only after the edge that follows the valid being seen low. The port returns to idle only once the valid has been seen low after a capture.
- R8: With `vectorEnable`=0, `irqTake` in the idle state loads `jumpTarget` with 0x00000018 when `highVectors`=0, or with 0xFFFF0018 when `highVectors`=1. `vecReady` pulses in the cycle after that edge, and `irqAck` stays 0.
- R9: A pending fast interrupt never raises `irqAck` and never changes `jumpTarget`.
- R10: `irqTake` is ignored while a handshake is in progress: `irqAck`, `vecReady` and `jumpTarget` follow the handshake already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fastReqN | input | 1 | Fast interrupt request, active low |
| normReqN | input | 1 | Normal interrupt request, active low |
| reqSyncBypass | input | 1 | 1 = both request inputs skip their synchronizers |
| validSyncBypass | input | 1 | 1 = the address-valid input skips its synchronizer |
| irqAddrValid | input | 1 | Controller strobe: the vector address is held stable |
| irqAddr | input | 30 | Handler address, bits 31 down to 2 |
| vectorEnable | input | 1 | 1 = fetch the vector by handshake; 0 = use the legacy vector |
| highVectors | input | 1 | Selects the high legacy vector base |
| irqTake | input | 1 | Processor starts normal-interrupt entry |
| irqAck | output | 1 | Acknowledge to the controller, active high |
| fiqPending | output | 1 | Synchronized fast interrupt pending |
| irqPending | output | 1 | Synchronized normal interrupt pending |
| vecReady | output | 1 | One-cycle pulse: `jumpTarget` has been updated |
| jumpTarget | output | 32 | Address at which interrupt entry continues |

## Verification
The assertions check the handshake ordering on every cycle:
- the acknowledge rises only after the synchronized valid has been seen low;
- it falls only after that valid has been seen high;
- it holds while it waits;
- `vecReady` never lasts more than one cycle, and every target it announces is word aligned.

Some behaviours need the bench's reference model and directed scenarios instead:
- the exact two-edge synchronizer delays and the same-cycle bypass paths;
- the captured address value and the choice between the two legacy vectors;
- a fast request or an extra `irqTake` during a handshake leaving the outputs unchanged.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  // Handshake progress of the vector fetch
  typedef enum logic [1:0] {
    HS_IDLE     = 2'd0,
    HS_WAIT_LOW = 2'd1,
    HS_ACK      = 2'd2,
    HS_RELEASE  = 2'd3
  } hsState_e;

  // Strobes from the controller into the datapath
  typedef struct packed {
    logic capVec;     // store the address from the controller
    logic capLegacy;  // store the fixed legacy vector
  } dpStrobe_t;

endpackage

// File: rtl/irq_sync_stage.sv
module irq_sync_stage #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic bypass,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chainQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {STAGES{RST_VAL}};
        else       chainQ <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {STAGES{RST_VAL}};
        else       chainQ <= {chainQ[STAGES-2:0], din};
      end
    end
  endgenerate

  // The bypass path is a plain wire; the last stage is the resynchronized copy.
  assign dout = bypass ? din : chainQ[STAGES-1];

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqTake,
  input  logic      vectorEnable,
  input  logic      validS,
  output dpStrobe_t strobe,
  output logic      ackQ,
  output logic      vecReadyQ
);

  hsState_e stateQ, stateD;

  always_comb begin
    stateD           = stateQ;
    strobe.capVec    = 1'b0;
    strobe.capLegacy = 1'b0;
    unique case (stateQ)
      HS_IDLE: begin
        if (irqTake) begin
          if (!vectorEnable) begin
            strobe.capLegacy = 1'b1;
            stateD           = HS_RELEASE;
          end else if (validS) begin
            stateD = HS_WAIT_LOW;   // previous strobe still up
          end else begin
            stateD = HS_ACK;
          end
        end
      end
      HS_WAIT_LOW: if (!validS) stateD = HS_ACK;
      HS_ACK: begin
        if (validS) begin
          strobe.capVec = 1'b1;
          stateD        = HS_RELEASE;
        end
      end
      HS_RELEASE: if (!validS) stateD = HS_IDLE;
      default: stateD = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= HS_IDLE;
      ackQ      <= 1'b0;
      vecReadyQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      ackQ      <= (stateD == HS_ACK);
      vecReadyQ <= strobe.capVec | strobe.capLegacy;
    end
  end

  // R7: the acknowledge only rises after the valid was seen low
  assert_ack_rise_after_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackQ) |-> $past(!validS));

  // R6: the acknowledge only falls once the valid was seen high
  assert_ack_fall_after_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackQ) |-> $past(validS));

  // R6: a waiting acknowledge is held
  assert_ack_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ && !validS) |=> ackQ);

  // R6: the ready indication is a single-cycle pulse
  assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecReadyQ |=> !vecReadyQ);

endmodule

// File: rtl/irq_vector_dpath.sv
module irq_vector_dpath
  import irq_vector_pkg::*;
#(
  parameter int                ADDR_W   = 30,
  parameter logic [ADDR_W+1:0] LOW_VEC  = 'h18,
  parameter logic [ADDR_W+1:0] HIGH_VEC = 'hFFFF0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] irqAddr,
  input  logic              highVectors,
  output logic [ADDR_W+1:0] jumpTarget
);

  localparam int TGT_W = ADDR_W + 2;

  logic [TGT_W-1:0] targetQ;
  logic [TGT_W-1:0] legacyVec;

  assign legacyVec = highVectors ? HIGH_VEC : LOW_VEC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 targetQ <= '0;
    else if (strobe.capVec)    targetQ <= {irqAddr, 2'b00};
    else if (strobe.capLegacy) targetQ <= legacyVec;
  end

  assign jumpTarget = targetQ;

  // R8: a legacy load always yields one of the two fixed vectors
  assert_legacy_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLegacy |=> (jumpTarget == LOW_VEC || jumpTarget == HIGH_VEC));

  // R6: with no load strobe, the target register keeps its value
  assert_target_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capVec || strobe.capLegacy) |=> $stable(jumpTarget));

endmodule

// File: rtl/irq_vector_port.sv
module irq_vector_port
  import irq_vector_pkg::*;
#(
  parameter int ADDR_W      = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastReqN,
  input  logic              normReqN,
  input  logic              reqSyncBypass,
  input  logic              validSyncBypass,
  input  logic              irqAddrValid,
  input  logic [ADDR_W-1:0] irqAddr,
  input  logic              vectorEnable,
  input  logic              highVectors,
  input  logic              irqTake,
  output logic              irqAck,
  output logic              fiqPending,
  output logic              irqPending,
  output logic              vecReady,
  output logic [ADDR_W+1:0] jumpTarget
);

  localparam int NUM_REQ = 2;

  logic [NUM_REQ-1:0] reqRawN;
  logic [NUM_REQ-1:0] reqSyncN;
  logic               validS;
  dpStrobe_t          strobe;

  assign reqRawN = {normReqN, fastReqN};

  // Request lines idle high, so their synchronizers reset high.
  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_reqSync
      irq_sync_stage #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) reqSync_i (
        .clk(clk), .rstN(rstN), .bypass(reqSyncBypass),
        .din(reqRawN[i]), .dout(reqSyncN[i]));
    end
  endgenerate

  irq_sync_stage #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) validSync_i (
    .clk(clk), .rstN(rstN), .bypass(validSyncBypass),
    .din(irqAddrValid), .dout(validS));

  assign fiqPending = ~reqSyncN[0];
  assign irqPending = ~reqSyncN[1];

  irq_vector_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .irqTake(irqTake), .vectorEnable(vectorEnable),
    .validS(validS), .strobe(strobe), .ackQ(irqAck), .vecReadyQ(vecReady));

  irq_vector_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqAddr(irqAddr),
    .highVectors(highVectors), .jumpTarget(jumpTarget));

  // R6: every announced target is word aligned
  assert_target_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecReady |-> (jumpTarget[1:0] == 2'b00));

endmodule

// File: tb/irq_vector_port_tb.sv
`timescale 1ns/1ps
module irq_vector_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fastReqN = 1'b1, normReqN = 1'b1;
  logic        reqSyncBypass = 1'b0, validSyncBypass = 1'b0;
  logic        irqAddrValid = 1'b0;
  logic [29:0] irqAddr = '0;
  logic        vectorEnable = 1'b1, highVectors = 1'b0, irqTake = 1'b0;
  logic        irqAck, fiqPending, irqPending, vecReady;
  logic [31:0] jumpTarget;

  always #2.5 clk = ~clk;   // 200 MHz

  irq_vector_port dut_i (
    .clk(clk), .rstN(rstN), .fastReqN(fastReqN), .normReqN(normReqN),
    .reqSyncBypass(reqSyncBypass), .validSyncBypass(validSyncBypass),
    .irqAddrValid(irqAddrValid), .irqAddr(irqAddr),
    .vectorEnable(vectorEnable), .highVectors(highVectors), .irqTake(irqTake),
    .irqAck(irqAck), .fiqPending(fiqPending), .irqPending(irqPending),
    .vecReady(vecReady), .jumpTarget(jumpTarget));

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    done = 0;

  // Reference model: delay lines as queues, handshake as an integer phase.
  bit          fastHist[$], normHist[$], validHist[$];
  int          phase;          // 0 idle, 1 wait for low, 2 acking, 3 finishing
  bit          mRdy;
  logic [31:0] mTgt;

  function automatic void model_reset();
    fastHist  = '{1'b1, 1'b1};
    normHist  = '{1'b1, 1'b1};
    validHist = '{1'b0, 1'b0};
    phase = 0; mRdy = 0; mTgt = 32'h0;
  endfunction

  function automatic bit seen_valid();
    return validSyncBypass ? irqAddrValid : validHist[1];
  endfunction

  initial model_reset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) model_reset();
    else begin
      bit v;
      bit rdyNext;
      v = seen_valid();
      rdyNext = 0;
      case (phase)
        0: if (irqTake) begin
             if (!vectorEnable) begin
               mTgt = highVectors ? 32'hFFFF0018 : 32'h00000018;
               rdyNext = 1; phase = 3;
             end else phase = v ? 1 : 2;
           end
        1: if (!v) phase = 2;
        2: if (v) begin mTgt = {irqAddr, 2'b00}; rdyNext = 1; phase = 3; end
        default: if (!v) phase = 0;
      endcase
      mRdy = rdyNext;
      void'(fastHist.pop_back());  fastHist.push_front(fastReqN);
      void'(normHist.pop_back());  normHist.push_front(normReqN);
      void'(validHist.pop_back()); validHist.push_front(irqAddrValid);
    end
  end

  // Compare every cycle on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      bit expFiq, expIrq, expAck;
      expFiq = !(reqSyncBypass ? fastReqN : fastHist[1]);
      expIrq = !(reqSyncBypass ? normReqN : normHist[1]);
      expAck = (phase == 2);
      compared++;
      if (fiqPending !== expFiq || irqPending !== expIrq || irqAck !== expAck ||
          vecReady !== mRdy || jumpTarget !== mTgt) begin
        mismatched++;
        $display("FAIL %s t=%0t act fiq=%b irq=%b ack=%b rdy=%b tgt=%h exp fiq=%b irq=%b ack=%b rdy=%b tgt=%h",
                 curReq, $time, fiqPending, irqPending, irqAck, vecReady, jumpTarget,
                 expFiq, expIrq, expAck, mRdy, mTgt);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic take_pulse();
    irqTake = 1'b1; step(1); irqTake = 1'b0;
  endtask

  // Controller side of one vectored fetch
  task automatic serve(input logic [29:0] addr, input int dly, input bit extraTake);
    int guard = 0;
    while (!irqAck && guard < 60) begin step(1); guard++; end
    if (extraTake) take_pulse();           // R10: ignored while acknowledging
    step(dly);
    irqAddr = addr; irqAddrValid = 1'b1;
    guard = 0;
    while (irqAck && guard < 60) begin step(1); guard++; end
    step(2);
    irqAddrValid = 1'b0;
    step(5);
  endtask

  initial begin
    curReq = "R1";
    step(4);
    rstN = 1'b1;
    step(2);

    // R2 / R3: request polarity, synchronized and bypassed
    curReq = "R3";
    fastReqN = 1'b0; step(4); fastReqN = 1'b1; step(4);
    normReqN = 1'b0; step(3); normReqN = 1'b1; step(3);
    curReq = "R2";
    reqSyncBypass = 1'b1;
    fastReqN = 1'b0; step(2); normReqN = 1'b0; step(2);
    fastReqN = 1'b1; normReqN = 1'b1; step(2);
    reqSyncBypass = 1'b0; step(3);

    // R5 / R6 / R4: vectored fetch with the valid synchronized, then bypassed
    curReq = "R6";
    normReqN = 1'b0;
    take_pulse(); serve(30'h2AAA_5555, 2, 0);
    curReq = "R4";
    validSyncBypass = 1'b1;
    take_pulse(); serve(30'h0000_0011, 0, 0);
    validSyncBypass = 1'b0;
    curReq = "R5";
    reqSyncBypass = 1'b1;
    take_pulse(); serve(30'h3FFF_FFFF, 4, 0);
    reqSyncBypass = 1'b0;

    // R10: extra entry request during an active handshake
    curReq = "R10";
    take_pulse(); serve(30'h1234_5678, 3, 1);

    // R7: entry while the previous valid is still high
    curReq = "R7";
    irqAddrValid = 1'b1; step(4);
    take_pulse(); step(5);
    irqAddrValid = 1'b0;
    serve(30'h0BAD_0C0D, 1, 0);

    // R9: fast request alone never acknowledges
    curReq = "R9";
    normReqN = 1'b1;
    fastReqN = 1'b0; step(10); fastReqN = 1'b1; step(4);

    // R8: legacy vectors in both modes
    curReq = "R8";
    vectorEnable = 1'b0;
    highVectors = 1'b0; take_pulse(); step(5);
    highVectors = 1'b1; take_pulse(); step(5);
    irqTake = 1'b1; step(4); irqTake = 1'b0; step(4);
    vectorEnable = 1'b1; highVectors = 1'b0;

    // R1: reset in the middle of an acknowledge
    curReq = "R1";
    take_pulse(); step(2);
    rstN = 1'b0; step(3); rstN = 1'b1; step(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL %s watchdog act cycles=%0d exp below 20000", curReq, cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule